// File: doc/BRIEF.md
# Operand Forwarding Select Unit

This block is the execute-stage bypass control of a five-stage in-order pipeline. Each cycle it compares the two source register numbers of the instruction now in execute against the destination registers of the two older instructions still in flight. One older instruction sits just past execute and the other is in write-back. For each operand it produces a 2-bit select code that chooses among three values: the register-file value read at decode, the result one stage ahead, or the value about to be written back.

Without bypassing, a dependent instruction right behind its producer waits two cycles. With this unit that dependency costs no cycles. The unit is purely combinational. It also holds the two operand multiplexers and the write-back value mux, which picks between the ALU result and the loaded data. The select codes can then be checked against the operand values they steer. Stalls for a load followed by a use are handled elsewhere.

Top module: `fwd_select`

## Requirements
- R1: `sel_a` is 2'b10 whenever `mem_wr_en` is 1, `mem_rd` is non-zero and `mem_rd` equals `rs_ex`.
- R2: `sel_b` is 2'b10 whenever `mem_wr_en` is 1, `mem_rd` is non-zero and `mem_rd` equals `rt_ex`.
- R3: When an operand has no match in the memory stage, its select is 2'b01 if `wb_wr_en` is 1, `wb_rd` is non-zero and `wb_rd` equals that operand's source register.
- R4: When both older stages match the same source register, the memory-stage result (2'b10) wins.
- R5: A destination register number of 0 never causes forwarding, even with its write enable set.
- R6: A stage whose write enable is 0 never causes forwarding, even when its register number matches.
- R7: With no qualifying match, the select is 2'b00 and the operand output equals the register-file value (`rf_a` for A, `rf_b` for B).
- R8: The forwarded write-back value is `wb_load` when `wb_sel_load` is 1 and `wb_alu` when it is 0.
- R9: Each operand output is the source its select names: 2'b00 register file, 2'b10 `mem_result`, 2'b01 write-back value. The code 2'b11 never appears.
- R10: The two operands are resolved independently. In the same cycle A and B may take different sources.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rs_ex | input | RW | First source register number of the instruction in execute |
| rt_ex | input | RW | Second source register number of the instruction in execute |
| rf_a | input | DW | Register-file value read for the first source |
| rf_b | input | DW | Register-file value read for the second source |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_rd | input | RW | Memory-stage destination register number |
| mem_result | input | DW | Memory-stage ALU result |
| wb_wr_en | input | 1 | Write-back instruction writes a register |
| wb_rd | input | RW | Write-back destination register number |
| wb_alu | input | DW | Write-back ALU result |
| wb_load | input | DW | Write-back loaded data |
| wb_sel_load | input | 1 | 1 selects loaded data as the write-back value |
| sel_a | output | 2 | Source select for operand A |
| sel_b | output | 2 | Source select for operand B |
| opnd_a | output | DW | Operand A to the ALU |
| opnd_b | output | DW | Operand B to the ALU |

## Verification
The bench targets cases where both older stages name the same register. A unit with the priority reversed would feed the ALU a stale value from two instructions back. It also drives destination register 0 with the write enable set, and a matching register number with the write enable clear. A unit missing either qualifier would bypass a value that never reaches the register file. The bench also mixes sources across the two operands and uses equal source numbers. This exposes a unit that shares one comparison between both operands. Finally it flips the load/ALU choice in write-back, which catches a bypass path that ignores that choice.

// File: rtl/fwd_select.sv
module fwd_select #(
  parameter int RW = 5,
  parameter int DW = 32
) (
  input  logic [RW-1:0] rs_ex,
  input  logic [RW-1:0] rt_ex,
  input  logic [DW-1:0] rf_a,
  input  logic [DW-1:0] rf_b,
  input  logic          mem_wr_en,
  input  logic [RW-1:0] mem_rd,
  input  logic [DW-1:0] mem_result,
  input  logic          wb_wr_en,
  input  logic [RW-1:0] wb_rd,
  input  logic [DW-1:0] wb_alu,
  input  logic [DW-1:0] wb_load,
  input  logic          wb_sel_load,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic [DW-1:0] opnd_a,
  output logic [DW-1:0] opnd_b
);
  localparam logic [1:0] SRC_RF  = 2'b00;
  localparam logic [1:0] SRC_MEM = 2'b10;
  localparam logic [1:0] SRC_WB  = 2'b01;

  logic          mem_live, wb_live;
  logic [DW-1:0] wb_value;

  assign mem_live = mem_wr_en && (mem_rd != '0);
  assign wb_live  = wb_wr_en  && (wb_rd  != '0);
  assign wb_value = wb_sel_load ? wb_load : wb_alu;

  function automatic logic [1:0] pick(input logic [RW-1:0] src);
    if (mem_live && mem_rd == src)     return SRC_MEM;
    else if (wb_live && wb_rd == src)  return SRC_WB;
    else                               return SRC_RF;
  endfunction

  function automatic logic [DW-1:0] steer(input logic [1:0] sel,
                                          input logic [DW-1:0] rf);
    case (sel)
      SRC_MEM: return mem_result;
      SRC_WB:  return wb_value;
      default: return rf;
    endcase
  endfunction

  assign sel_a  = pick(rs_ex);
  assign sel_b  = pick(rt_ex);
  assign opnd_a = steer(sel_a, rf_a);
  assign opnd_b = steer(sel_b, rf_b);
endmodule

// File: rtl/fwd_select_chk.sv
module fwd_select_chk #(
  parameter int RW = 5,
  parameter int DW = 32
) (
  input logic [RW-1:0] rs_ex,
  input logic [RW-1:0] rt_ex,
  input logic [DW-1:0] rf_a,
  input logic [DW-1:0] rf_b,
  input logic          mem_wr_en,
  input logic [RW-1:0] mem_rd,
  input logic [DW-1:0] mem_result,
  input logic          wb_wr_en,
  input logic [RW-1:0] wb_rd,
  input logic [DW-1:0] wb_alu,
  input logic [DW-1:0] wb_load,
  input logic          wb_sel_load,
  input logic [1:0]    sel_a,
  input logic [1:0]    sel_b,
  input logic [DW-1:0] opnd_a,
  input logic [DW-1:0] opnd_b
);
  always_comb begin
    if (mem_wr_en && mem_rd != '0 && mem_rd == rs_ex)
      AST_MEM_WINS_A: assert (sel_a == 2'b10);                     // R1
    if (mem_wr_en && mem_rd != '0 && mem_rd == rt_ex)
      AST_MEM_WINS_B: assert (sel_b == 2'b10);                     // R2
    if (mem_rd == '0 && wb_rd == '0)
      AST_ZERO_DEST: assert (sel_a == 2'b00 && sel_b == 2'b00);    // R5
    if (!mem_wr_en && !wb_wr_en)
      AST_NO_WRITE: assert (sel_a == 2'b00 && sel_b == 2'b00);     // R6
    AST_SEL_LEGAL: assert ($onehot0(sel_a) && $onehot0(sel_b));   // R9
    if (sel_a == 2'b00)
      AST_RF_PASS_A: assert (opnd_a == rf_a);                      // R7
    if (sel_b == 2'b10)
      AST_MEM_DATA_B: assert (opnd_b == mem_result);               // R9
    if (sel_a == 2'b01)
      AST_WB_DATA_A: assert (opnd_a == (wb_sel_load ? wb_load : wb_alu)); // R8
  end
endmodule

bind fwd_select fwd_select_chk #(.RW(RW), .DW(DW)) i_chk (.*);

// File: tb/test_fwd_select.sv
module test_fwd_select;
  localparam int RW = 5;
  localparam int DW = 32;

  logic clk = 0;
  always #10 clk = ~clk;

  logic [RW-1:0] rs_ex = '0, rt_ex = '0, mem_rd = '0, wb_rd = '0;
  logic [DW-1:0] rf_a = '0, rf_b = '0, mem_result = '0, wb_alu = '0, wb_load = '0;
  logic          mem_wr_en = 0, wb_wr_en = 0, wb_sel_load = 0;
  logic [1:0]    sel_a, sel_b;
  logic [DW-1:0] opnd_a, opnd_b;

  fwd_select #(.RW(RW), .DW(DW)) i_fwd_select (.*);

  typedef struct {
    string         req;
    logic [1:0]    sa, sb;
    logic [DW-1:0] oa, ob;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic logic [1:0] model_sel(logic [RW-1:0] src);
    if (mem_wr_en && mem_rd != 0 && mem_rd == src) return 2'b10;
    if (wb_wr_en && wb_rd != 0 && wb_rd == src)    return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [DW-1:0] model_val(logic [1:0] s, logic [DW-1:0] rf);
    if (s == 2'b10) return mem_result;
    if (s == 2'b01) return wb_sel_load ? wb_load : wb_alu;
    return rf;
  endfunction

  task automatic drive(string req, logic [RW-1:0] rs, logic [RW-1:0] rt,
                       logic mwe, logic [RW-1:0] mrd,
                       logic wwe, logic [RW-1:0] wrd, logic ld);
    item_t it;
    @(negedge clk);
    rs_ex = rs; rt_ex = rt; mem_wr_en = mwe; mem_rd = mrd;
    wb_wr_en = wwe; wb_rd = wrd; wb_sel_load = ld;
    rf_a = 32'hA000_0000 | rs; rf_b = 32'hB000_0000 | rt;
    mem_result = 32'h1111_0000 | mrd; wb_alu = 32'h2222_0000 | wrd;
    wb_load = 32'h3333_0000 | wrd;
    it.req = req;
    it.sa = model_sel(rs); it.sb = model_sel(rt);
    it.oa = model_val(it.sa, rf_a); it.ob = model_val(it.sb, rf_b);
    q.push_back(it);
  endtask

  task automatic cmp(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      cmp(it.req, "sel_a", {30'd0, sel_a}, {30'd0, it.sa});
      cmp(it.req, "sel_b", {30'd0, sel_b}, {30'd0, it.sb});
      cmp(it.req, "opnd_a", opnd_a, it.oa);
      cmp(it.req, "opnd_b", opnd_b, it.ob);
    end
  end

  initial begin
    drive("R7 idle", 0, 0, 0, 0, 0, 0, 0);
    drive("R7 no match", 4, 6, 1, 9, 1, 12, 0);
    drive("R1 mem to A", 3, 7, 1, 3, 0, 0, 0);
    drive("R2 mem to B", 5, 8, 1, 8, 0, 0, 0);
    drive("R3 wb alu to A", 10, 2, 0, 0, 1, 10, 0);
    drive("R8 wb load to B", 1, 13, 0, 0, 1, 13, 1);
    drive("R8 wb alu to B", 1, 13, 0, 0, 1, 13, 0);
    drive("R4 both match A", 6, 2, 1, 6, 1, 6, 1);
    drive("R4 both match B", 2, 6, 1, 6, 1, 6, 0);
    drive("R5 zero dest", 0, 0, 1, 0, 1, 0, 1);
    drive("R6 write disabled", 7, 9, 0, 7, 0, 9, 0);
    drive("R10 A mem B wb", 4, 11, 1, 4, 1, 11, 1);
    drive("R9 same source", 15, 15, 1, 15, 0, 15, 0);
    drive("R3 wb when mem off", 20, 20, 0, 20, 1, 20, 1);
    @(negedge clk); @(negedge clk);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 2000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule